// File: doc/BRIEF.md
# Oversampled Packet Detector with Hold-Off

The block takes one signed sample per clock from a pulse-compression receiver and reduces each sample to a single bit with a programmable level. Every symbol is carried by eight consecutive samples. Because the symbol phase is unknown, the block keeps a long history of these bits. On every clock it reads out a 24-bit candidate frame by taking one bit from every eighth position of that history.

A candidate is accepted when its top nibble is all ones and its low nibble equals the 4-bit wrapped sum of the other five nibbles. On acceptance the 16 middle bits go out on `payload_o` with a one-clock `valid_o` pulse. One frame stays aligned for up to eight consecutive sample phases, so a hold-off counter then blocks further acceptances for a parameterised number of clocks. Detection re-arms on its own when the counter expires.

Bits enter the frame in transmission order. The first bit sent lands in candidate bit 23 and the last bit sent in bit 0. So the preamble goes first, then the payload from its MSB down, then the check nibble.

Top module: `ovs_packet_detector`

## Requirements
- R1: A sample becomes a 1 bit only when, read as signed, it is strictly greater than `thr_i` read as signed. A sample equal to the threshold gives 0.
- R2: Candidate bit k (k = 0..23) is the bit taken 8·k clocks before the newest one. The newest bit is bit 0, so the window spans 185 samples.
- R3: A candidate is rejected unless bits 23..20 are all ones.
- R4: A candidate is rejected unless bits 3..0 equal, modulo 16, the sum of the nibbles at bits 23..20, 19..16, 15..12, 11..8 and 7..4.
- R5: For an accepted candidate, `payload_o` carries candidate bits 19..4 and `valid_o` is high for one clock. Both appear one clock after the sample that completed the candidate.
- R6: After an acceptance, no further acceptance occurs during the next HOLDOFF clocks (default 32; legal range 8 to 192). Detection resumes automatically after that.
- R7: A clean frame, with each bit held for eight samples and any leading sample offset, yields exactly one `valid_o` pulse.
- R8: After reset `valid_o` is 0, `payload_o` is 0, the bit history is all zeros and no hold-off is pending.
- R9: `payload_o` keeps its last value until the next `valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, one sample per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | SAMPLE_W | Signed compressed sample |
| thr_i | input | SAMPLE_W | Signed decision level |
| valid_o | output | 1 | One-clock pulse for an accepted frame |
| payload_o | output | 16 | Payload of the last accepted frame |

## Verification
A sample driven before rising edge n enters the bit history at edge n, and the acceptance decision is made on that history during the following cycle. The resulting `valid_o` and `payload_o` update at edge n+1. The bench drives on falling edges and runs its own history, hold-off and payload model. It compares each cycle's outputs with the model value computed two falling edges earlier, which matches that one-register latency. Directed segments count pulses over a window long enough for the frame and its full hold-off to elapse.

// File: rtl/ovs_pkt_pkg.sv
package ovs_pkt_pkg;
  localparam int PKT_W = 24;
  localparam int PRE_W = 4;
  localparam int CHK_W = 4;
  localparam int PAY_W = PKT_W - PRE_W - CHK_W;
  localparam int NIBS  = (PKT_W - CHK_W) / CHK_W;

  typedef logic [PKT_W-1:0] pkt_t;

  function automatic logic [CHK_W-1:0] nib_sum(input pkt_t p);
    logic [CHK_W-1:0] acc;
    acc = '0;
    for (int i = 1; i <= NIBS; i++) acc = acc + p[i*CHK_W +: CHK_W];
    return acc;
  endfunction
endpackage

// File: rtl/ovs_thresh.sv
module ovs_thresh #(
  parameter int SAMPLE_W = 16
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] thr_i,
  output logic                hit_o
);
  assign hit_o = $signed(sample_i) > $signed(thr_i);
endmodule

// File: rtl/ovs_tap_shreg.sv
module ovs_tap_shreg #(
  parameter int OSR  = 8,
  parameter int TAPS = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bit_i,
  output logic [TAPS-1:0] cand_o
);
  localparam int LEN = (TAPS - 1) * OSR + 1;

  logic [LEN-1:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shreg_q <= '0;
    else         shreg_q <= {shreg_q[LEN-2:0], bit_i};
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign cand_o[k] = shreg_q[k*OSR];
  end
endmodule

// File: rtl/ovs_frame_check.sv
module ovs_frame_check
  import ovs_pkt_pkg::*;
(
  input  pkt_t             cand_i,
  output logic             match_o,
  output logic [PAY_W-1:0] payload_o
);
  logic pre_ok, chk_ok;

  assign pre_ok    = &cand_i[PKT_W-1 -: PRE_W];
  assign chk_ok    = cand_i[CHK_W-1:0] == nib_sum(cand_i);
  assign match_o   = pre_ok && chk_ok;
  assign payload_o = cand_i[PKT_W-PRE_W-1:CHK_W];
endmodule

// File: rtl/ovs_holdoff.sv
module ovs_holdoff #(
  parameter int HOLDOFF = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  output logic det_o
);
  localparam int CNT_W = $clog2(HOLDOFF + 1);

  logic [CNT_W-1:0] cnt_q;

  assign det_o = match_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (det_o)       cnt_q <= CNT_W'(HOLDOFF);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/ovs_packet_detector.sv
module ovs_packet_detector
  import ovs_pkt_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int OSR      = 8,
  parameter int HOLDOFF  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] thr_i,
  output logic                valid_o,
  output logic [PAY_W-1:0]    payload_o
);
  localparam int GAP_W = $clog2(HOLDOFF + 1);

  logic             hit;
  pkt_t             cand;
  logic             match, det;
  logic [PAY_W-1:0] pay;
  logic             valid_q;
  logic [PAY_W-1:0] payload_q;

  ovs_thresh #(.SAMPLE_W(SAMPLE_W)) u_thresh (
    .sample_i(sample_i), .thr_i(thr_i), .hit_o(hit)
  );

  ovs_tap_shreg #(.OSR(OSR), .TAPS(PKT_W)) u_shreg (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(hit), .cand_o(cand)
  );

  ovs_frame_check u_check (
    .cand_i(cand), .match_o(match), .payload_o(pay)
  );

  ovs_holdoff #(.HOLDOFF(HOLDOFF)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .match_i(match), .det_o(det)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      payload_q <= '0;
    end else begin
      valid_q <= det;
      if (det) payload_q <= pay;
    end
  end

  assign valid_o   = valid_q;
  assign payload_o = payload_q;

  // clocks since last pulse, saturating; support for the spacing check
  logic [GAP_W-1:0] gap_q;
  logic             seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (valid_q) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != GAP_W'(HOLDOFF)) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_THRESH_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($signed(sample_i) > $signed(thr_i)) |=> cand[0]); // R1
  AST_PREAMBLE_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(cand[PKT_W-1 -: PRE_W]) == '1)); // R3
  AST_HOLDOFF_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && seen_q) |-> (gap_q >= GAP_W'(HOLDOFF))); // R6
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R6
  AST_PAYLOAD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(payload_o)); // R9
endmodule

// File: tb/ovs_packet_detector_bench.sv
module ovs_packet_detector_bench;
  localparam int HOLD = 32;
  localparam int OSR  = 8;
  localparam int LEN  = 23 * OSR + 1;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] sample_i;
  logic signed [15:0] thr_i;
  logic        valid_o;
  logic [15:0] payload_o;

  int checks = 0, failures = 0, pulses = 0;
  bit hist [LEN];
  int mhold = 0;
  bit d1 = 0, d2 = 0;
  logic [15:0] p1 = '0, p2 = '0, exp_pay = '0;

  always #5 clk_i = ~clk_i;

  ovs_packet_detector #(.SAMPLE_W(16), .OSR(OSR), .HOLDOFF(HOLD)) u_ovs_packet_detector (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .thr_i(thr_i),
    .valid_o(valid_o), .payload_o(payload_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] sum4(input logic [23:0] p);
    logic [3:0] s;
    s = p[23:20] + p[19:16] + p[15:12] + p[11:8] + p[7:4];
    return s;
  endfunction

  function automatic logic [23:0] mk_pkt(input logic [15:0] pay);
    logic [23:0] p;
    p = {4'hF, pay, 4'h0};
    p[3:0] = sum4(p);
    return p;
  endfunction

  function automatic logic [15:0] one_s();
    int v;
    v = int'(thr_i) + 1 + int'($urandom_range(0, 2000));
    return v[15:0];
  endfunction

  function automatic logic [15:0] zero_s();
    int v;
    v = int'(thr_i) - int'($urandom_range(0, 2000));
    return v[15:0];
  endfunction

  // called at a falling edge; leaves at the next falling edge
  task automatic step(input logic [15:0] s);
    logic [23:0] c;
    bit det;
    chk(valid_o === d2, "R5 R6", "valid_o", int'(valid_o), int'(d2));
    if (d2) exp_pay = p2;
    chk(payload_o === exp_pay, "R5 R9", "payload_o", int'(payload_o), int'(exp_pay));
    if (valid_o === 1'b1) pulses++;
    sample_i = s;
    for (int i = LEN - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = $signed(s) > thr_i;
    for (int k = 0; k < 24; k++) c[k] = hist[k*OSR];
    det = (c[23:20] == 4'hF) && (c[3:0] == sum4(c)) && (mhold == 0);
    if (det) mhold = HOLD;
    else if (mhold > 0) mhold--;
    d2 = d1; p2 = p1;
    d1 = det; p1 = c[19:4];
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(zero_s());
  endtask

  task automatic send_pkt(input logic [23:0] p, input bit at_thr);
    for (int b = 23; b >= 0; b--)
      for (int j = 0; j < OSR; j++)
        step(p[b] ? (at_thr ? 16'(thr_i) : one_s()) : zero_s());
  endtask

  initial begin
    logic [23:0] p;
    logic [15:0] pay;
    void'($urandom(32'd42));
    for (int i = 0; i < LEN; i++) hist[i] = 1'b0;
    rst_ni = 1'b0; thr_i = 16'sd1000; sample_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk(valid_o === 1'b0, "R8", "reset valid_o", int'(valid_o), 0);
    chk(payload_o === 16'h0, "R8", "reset payload_o", int'(payload_o), 0);

    // clean frame, random phase: one pulse, correct mapping, held payload
    pulses = 0;
    idle($urandom_range(0, 7));
    send_pkt(mk_pkt(16'h5D39), 1'b0);
    idle(250);
    chk(pulses == 1, "R7 R6", "pulse count clean", pulses, 1);
    chk(payload_o === 16'h5D39, "R2 R9", "payload after idle", int'(payload_o), 16'h5D39);

    // bad check nibble
    pulses = 0;
    p = mk_pkt(16'hA0C3); p[0] = ~p[0];
    idle($urandom_range(0, 7));
    send_pkt(p, 1'b0); idle(250);
    chk(pulses == 0, "R4", "pulse count bad check", pulses, 0);

    // bad preamble, check nibble consistent
    pulses = 0;
    p = mk_pkt(16'h1234); p[22] = 1'b0; p[3:0] = sum4(p);
    send_pkt(p, 1'b0); idle(250);
    chk(pulses == 0, "R3", "pulse count bad preamble", pulses, 0);

    // ones exactly at threshold decode as zeros
    pulses = 0;
    send_pkt(mk_pkt(16'hFFFF), 1'b1); idle(250);
    chk(pulses == 0, "R1", "pulse count at threshold", pulses, 0);
    pulses = 0;
    send_pkt(mk_pkt(16'hFFFF), 1'b0); idle(250);
    chk(pulses == 1, "R1", "pulse count above threshold", pulses, 1);
    chk(payload_o === 16'hFFFF, "R5", "payload all ones", int'(payload_o), 16'hFFFF);

    // random frames, random gaps including back-to-back
    for (int n = 0; n < 30; n++) begin
      pay = 16'($urandom);
      send_pkt(mk_pkt(pay), 1'b0);
      idle(($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 60));
    end

    // negative threshold
    thr_i = -16'sd500;
    for (int n = 0; n < 20; n++) begin
      pay = 16'($urandom);
      send_pkt(mk_pkt(pay), 1'b0);
      idle($urandom_range(0, 40));
    end
    idle(250);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule